// File: doc/BRIEF.md
# Fetch Redirect with Jump Squash

This block is the instruction-fetch front end of a five-stage in-order pipeline. It owns the program counter. Each cycle it presents one address to the instruction memory and takes back one 32-bit word. It always guesses that execution falls through to the next sequential word, four bytes on. Fetched words go into a fetch/decode register, which is the decoded-instruction output seen by the rest of the pipeline.

The block checks the entry in decode for an unconditional PC-relative jump. When it finds one, a dedicated adder forms the target. In that same cycle a kill multiplexer replaces the word just fetched with a no-op, and the program counter loads the target. The architecture has no delay slot, so each taken jump costs exactly one bubble. A stall input freezes the whole front end. A jump held in decode under stall redirects exactly once, after the stall clears.

The program counter register doubles as the memory's address register. The memory returns the word for `imem_addr_o` within the same cycle.

Top module: `fetch_redirect`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the fetch address to the parameter RESET_VEC and leaves decode holding the all-zero no-op word with dec_valid_o low.
- R2: When no jump is taken in decode and stall_i is low, the fetch address advances by exactly 4 per cycle.
- R3: When no jump is in decode and stall_i is low, the word read at the current fetch address appears on dec_instr_o one cycle later, with that address on dec_pc_o and dec_valid_o high.
- R4: A valid decode entry counts as a jump when bits [31:26] equal 6'b000010 (jump) or 6'b000011 (jump-and-link). Its target is the decode PC plus the sign-extended 26-bit field [25:0] shifted left by 2, so backward offsets are supported.
- R5: In the cycle after a jump is taken, decode holds the all-zero word with dec_valid_o low. The fall-through word fetched alongside the jump never reaches decode.
- R6: In the cycle after a jump is taken, the fetch address equals that jump's target.
- R7: While stall_i is high, the fetch address and all decode outputs keep their values.
- R8: A jump held in decode under stall redirects only after stall_i falls, and it loads its target exactly once.
- R9: A chain of jumps, each targeting another jump, yields one valid decode entry every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freezes the PC and the fetch/decode register |
| imem_addr_o | output | 32 | Fetch address (current PC) |
| imem_rdata_i | input | 32 | Instruction word for imem_addr_o, same cycle |
| dec_instr_o | output | 32 | Instruction in decode (zero when squashed) |
| dec_pc_o | output | 32 | Address of the instruction in decode |
| dec_valid_o | output | 1 | Decode entry holds a live instruction |

## Verification
The assertions assume three things about the inputs: stall_i and imem_rdata_i always carry known values, reset is applied synchronously, and the memory returns the word for the current address within the same cycle. The bench's memory model satisfies these. It is a pure function of the fetch address that defines a word for every address. The bench changes stall_i and rst only on the falling clock edge, so every property sees stable inputs at the rising edge. The jump program keeps all targets word-aligned and within the modelled range, so no fetch ever reads an undefined word.

// File: rtl/fr_pkg.sv
package fr_pkg;

  localparam int unsigned ILEN    = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned OFF_W   = ILEN - OPC_W;
  localparam int unsigned STEP    = 4;

  localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_JMPL = 6'b000011;
  localparam logic [ILEN-1:0]  NOP_WORD = '0;

  typedef struct packed {
    logic [ILEN-1:0] instr;
    logic [ILEN-1:0] pc;
    logic            valid;
  } fd_entry_t;

  function automatic logic [OPC_W-1:0] opcode_of(input logic [ILEN-1:0] w);
    return w[ILEN-1 -: OPC_W];
  endfunction

  function automatic logic is_jump(input logic [ILEN-1:0] w);
    logic [OPC_W-1:0] op;
    op = opcode_of(w);
    return (op == OPC_JMP) || (op == OPC_JMPL);
  endfunction

  function automatic logic [ILEN-1:0] jump_target(input logic [ILEN-1:0] pc,
                                                  input logic [ILEN-1:0] w);
    logic [ILEN-1:0] off;
    off = {{(OPC_W-2){w[OFF_W-1]}}, w[OFF_W-1:0], 2'b00};
    return pc + off;
  endfunction

  function automatic logic [ILEN-1:0] seq_next(input logic [ILEN-1:0] pc);
    return pc + ILEN'(STEP);
  endfunction

endpackage

// File: rtl/fr_jump_unit.sv
module fr_jump_unit
  import fr_pkg::*;
(
  input  fd_entry_t       dec_i,
  output logic            take_o,
  output logic [ILEN-1:0] target_o
);

  // Jump detection only trusts live entries; squashed bubbles never redirect.
  always_comb begin
    take_o   = dec_i.valid && is_jump(dec_i.instr);
    target_o = jump_target(dec_i.pc, dec_i.instr);
  end

endmodule

// File: rtl/fr_pc_reg.sv
module fr_pc_reg
  import fr_pkg::*;
#(
  parameter logic [ILEN-1:0] RESET_VEC = '0
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_i,
  input  logic            redirect_i,
  input  logic [ILEN-1:0] target_i,
  output logic [ILEN-1:0] pc_o
);

  logic [ILEN-1:0] pc_q;
  logic [ILEN-1:0] pc_d;

  always_comb begin
    if (stall_i)         pc_d = pc_q;
    else if (redirect_i) pc_d = target_i;
    else                 pc_d = seq_next(pc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_VEC;
    else     pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_PC_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !redirect_i) |=> (pc_q == $past(pc_q) + ILEN'(STEP))); // R2

  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && redirect_i) |=> (pc_q == $past(target_i))); // R6

  AST_PC_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(pc_q)); // R7

endmodule

// File: rtl/fr_fd_reg.sv
module fr_fd_reg
  import fr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_i,
  input  logic            kill_i,
  input  logic [ILEN-1:0] fetch_word_i,
  input  logic [ILEN-1:0] fetch_pc_i,
  output fd_entry_t       entry_o
);

  fd_entry_t q;
  fd_entry_t d;

  // Kill multiplexer: a taken jump in decode turns the fall-through fetch into a bubble.
  always_comb begin
    if (stall_i) begin
      d = q;
    end else if (kill_i) begin
      d.instr = NOP_WORD;
      d.pc    = fetch_pc_i;
      d.valid = 1'b0;
    end else begin
      d.instr = fetch_word_i;
      d.pc    = fetch_pc_i;
      d.valid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q.instr <= NOP_WORD;
      q.pc    <= '0;
      q.valid <= 1'b0;
    end else begin
      q <= d;
    end
  end

  assign entry_o = q;

  AST_FD_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && kill_i) |=> (!q.valid && q.instr == NOP_WORD)); // R5

  AST_FD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !kill_i) |=> (q.valid && q.instr == $past(fetch_word_i)
                               && q.pc == $past(fetch_pc_i))); // R3

  AST_FD_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(q)); // R7

endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fr_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        stall_i,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_rdata_i,
  output logic [31:0] dec_instr_o,
  output logic [31:0] dec_pc_o,
  output logic        dec_valid_o
);

  fd_entry_t       dec_entry;
  logic            jump_take;
  logic [ILEN-1:0] jump_tgt;
  logic [ILEN-1:0] fetch_pc;

  fr_jump_unit u_jump (
    .dec_i    (dec_entry),
    .take_o   (jump_take),
    .target_o (jump_tgt)
  );

  fr_pc_reg #(
    .RESET_VEC (RESET_VEC)
  ) u_pc (
    .clk        (clk),
    .rst        (rst),
    .stall_i    (stall_i),
    .redirect_i (jump_take),
    .target_i   (jump_tgt),
    .pc_o       (fetch_pc)
  );

  fr_fd_reg u_fd (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .kill_i       (jump_take),
    .fetch_word_i (imem_rdata_i),
    .fetch_pc_i   (fetch_pc),
    .entry_o      (dec_entry)
  );

  assign imem_addr_o = fetch_pc;
  assign dec_instr_o = dec_entry.instr;
  assign dec_pc_o    = dec_entry.pc;
  assign dec_valid_o = dec_entry.valid;

  AST_SINGLE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (jump_take && !stall_i) |=> !jump_take); // R8

  AST_STALLED_JUMP_WAITS: assert property (@(posedge clk) disable iff (rst)
    (jump_take && stall_i) |=> (jump_take && imem_addr_o == $past(imem_addr_o))); // R8

  AST_JUMP_OPCODE: assert property (@(posedge clk) disable iff (rst)
    jump_take |-> (dec_valid_o && (dec_instr_o[31:26] == 6'b000010
                                   || dec_instr_o[31:26] == 6'b000011))); // R4

endmodule

// File: tb/fetch_redirect_test.sv
module fetch_redirect_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] addr;
  logic [31:0] rdata;
  logic [31:0] dinstr;
  logic [31:0] dpc;
  logic        dvalid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_redirect #(.RESET_VEC(32'd96)) uut (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall),
    .imem_addr_o  (addr),
    .imem_rdata_i (rdata),
    .dec_instr_o  (dinstr),
    .dec_pc_o     (dpc),
    .dec_valid_o  (dvalid)
  );

  function automatic logic [31:0] mk_jump(input logic link, input int off);
    logic [25:0] o;
    o = 26'(off);
    return {(link ? 6'b000011 : 6'b000010), o};
  endfunction

  // Program image: jumps at chosen addresses, a unique plain word elsewhere.
  function automatic logic [31:0] word_at(input logic [31:0] a);
    case (a)
      32'd100: return mk_jump(1'b0, 51);   // to 304
      32'd308: return mk_jump(1'b1, -27);  // to 200
      32'd208: return mk_jump(1'b0, 1);    // to 212
      32'd212: return mk_jump(1'b0, 2);    // to 220
      32'd220: return mk_jump(1'b0, 2);    // to 228
      32'd228: return mk_jump(1'b0, 2);    // to 236
      default: return {6'b001000, a[25:0]};
    endcase
  endfunction

  assign rdata = word_at(addr);

  localparam int NROW = 19;
  localparam logic [31:0] EXP_ADDR [0:NROW-1] = '{
    32'd96,  32'd100, 32'd104, 32'd304, 32'd308, 32'd312, 32'd200,
    32'd204, 32'd208, 32'd212, 32'd212, 32'd216, 32'd220, 32'd224,
    32'd228, 32'd232, 32'd236, 32'd240, 32'd244 };
  localparam logic EXP_V [0:NROW-1] = '{
    1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
    1'b0, 1'b1, 1'b0, 1'b1, 1'b1 };
  localparam logic [31:0] EXP_DPC [0:NROW-1] = '{
    32'd0,   32'd96,  32'd100, 32'd0,   32'd304, 32'd308, 32'd0,
    32'd200, 32'd204, 32'd208, 32'd0,   32'd212, 32'd0,   32'd220,
    32'd0,   32'd228, 32'd0,   32'd236, 32'd240 };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_decode(input logic v, input logic [31:0] pc, input string tag);
    chk(dvalid == v, {tag, " valid"}, 32'(dvalid), 32'(v));
    if (v) begin
      chk(dpc == pc, {tag, " pc"}, dpc, pc);
      chk(dinstr == word_at(pc), {tag, " instr"}, dinstr, word_at(pc));
    end else begin
      chk(dinstr == 32'd0, {tag, " nop"}, dinstr, 32'd0);
    end
  endtask

  initial begin
    int live;
    live = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state before the first active edge
    chk(addr == 32'd96, "R1 reset addr", addr, 32'd96);
    // trace walk: R2 R4 R6 on the address, R3 R5 on decode
    for (int i = 0; i < NROW; i++) begin
      if (i > 0) tick();
      chk(addr == EXP_ADDR[i], "R2 R4 R6 fetch addr", addr, EXP_ADDR[i]);
      check_decode(EXP_V[i], EXP_DPC[i], "R3 R5 decode");
      if (i >= 10 && i <= 17 && dvalid) live++;
    end
    // R9: back-to-back jump chain, 8 cycles give 4 live entries
    chk(live == 4, "R9 throughput", 32'(live), 32'd4);

    // R1: mid-run reset
    @(negedge clk) rst = 1'b1;
    tick();
    chk(addr == 32'd96, "R1 addr", addr, 32'd96);
    chk(!dvalid && dinstr == 32'd0, "R1 decode", dinstr, 32'd0);
    @(negedge clk) rst = 1'b0;
    tick();
    tick();
    chk(dvalid && dpc == 32'd100, "R8 jump in decode", dpc, 32'd100);

    // R7: stall with a jump in decode
    @(negedge clk) stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(addr == 32'd104, "R7 stall addr", addr, 32'd104);
      chk(dvalid && dpc == 32'd100, "R7 stall decode", dpc, 32'd100);
    end
    @(negedge clk) stall = 1'b0;
    tick();
    chk(addr == 32'd304, "R8 redirect after stall", addr, 32'd304);
    check_decode(1'b0, 32'd0, "R8 squash after stall");
    tick();
    chk(addr == 32'd308, "R8 single redirect", addr, 32'd308);
    check_decode(1'b1, 32'd304, "R8 target decode");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule